// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

The block counts rising edges of a slow, free-running tick that comes from outside the system clock domain. It raises an event when the count reaches a programmable time-out. The tick is brought into the system clock domain through a synchronizer chain, and its rising edges are detected there. Software can restart the count at any time through a kick input. Depending on the two enable bits, a time-out does one of three things: it emits a one-cycle system reset pulse, it raises an interrupt, or it first raises an interrupt and then resets on the following time-out if nobody re-arms it.

Changes that could weaken the watchdog are protected: turning it off and changing the time-out. These changes are only accepted during a short window. An unlock write opens that window, and it lasts a fixed number of system clocks. A watchdog-caused reset sets a cause flag. While that flag is set, the watchdog cannot be switched off.

The register view is one byte, laid out as follows:
- bit 0: run
- bit 1: interrupt enable
- bit 2: interrupt flag (write one to clear)
- bit 3: unlock (reads one while the window is open)
- bits 7:4: prescale code

Top module: `wdt_guard`

## Requirements
- R1: After rst_ni is released, the register byte reads 0x00, and irq_o, sys_rst_o and cause_o are low.
- R2: The count advances only on rising edges of tick_i, seen after a two-flop synchronizer. The first rising edge after a kick counts as one tick when it arrives one system clock before the kick.
- R3: Prescale code c (bits 7:4) selects a time-out of 2^(BASE_LOG2+c) ticks for c from 0 to 9. Codes 10 to 15 give the same time-out as code 9.
- R4: With run (bit 0) set and interrupt enable (bit 1) clear, a time-out drives sys_rst_o high for exactly one system clock.
- R5: With bit 1 set and bit 0 clear, a time-out sets the interrupt flag (bit 2) and irq_o. It does not reset, and bit 1 stays set.
- R6: With bits 0 and 1 both set, a time-out sets the flag and clears bit 1 in the same clock. The next time-out then produces a reset pulse unless software sets bit 1 again.
- R7: A reset time-out sets cause_o and forces bit 0 to one. While cause_o is high, a windowed write of bit 0 as zero leaves bit 0 set. A cause_clr_i pulse clears cause_o.
- R8: A write with bits 3 and 0 set while the window is closed opens a window of WIN_CYCLES clocks. Bit 3 reads one while the window is open and zero once it has expired.
- R9: Outside the window, a write can set bit 0 and can write bit 1 and clear bit 2. It cannot clear bit 0 and cannot change bits 7:4.
- R10: The first write inside the window loads bits 0, 1 and 7:4 and closes the window. A write made after the window has expired is handled as in R9.
- R11: A kick_i pulse or an accepted windowed write restarts the count from zero.
- R12: The interrupt flag is cleared by writing one to bit 2 or by an irq_ack_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Free-running watchdog tick, asynchronous to clk_i |
| kick_i | input | 1 | Restart the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| cause_clr_i | input | 1 | Clears the reset-cause flag |
| rd_data_o | output | 8 | Register read view |
| irq_o | output | 1 | Interrupt request (the flag) |
| sys_rst_o | output | 1 | One-cycle system reset pulse |
| cause_o | output | 1 | Watchdog caused the last reset |

## Verification
The bench builds the block with BASE_LOG2 set to 2 and keeps the default four-clock window and two synchronizer stages. With that setting, code 0 times out after 4 ticks and the longest setting after 2048 ticks. Both the normal timing and the clamping of the reserved codes can therefore be measured to the exact clock. The tick runs at a quarter of the system clock, so the synchronizer latency and the phase of a kick against the tick matter, and the reference model reproduces both cycle by cycle.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int PS_MAX = 9;

  typedef struct packed {
    logic [3:0] ps;
    logic       unlock;
    logic       flag;
    logic       ie;
    logic       run;
  } wdt_reg_t;
endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= tick_i;
      else chain_q[g] <= chain_q[(g > 0) ? g-1 : 0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       clr_i,
  input  logic       rise_i,
  input  logic [3:0] ps_i,
  output logic       tmo_o
);
  localparam int CW = BASE_LOG2 + PS_MAX + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_v;
  logic [3:0]    eff;

  always_comb begin
    eff    = (int'(ps_i) > PS_MAX) ? 4'(PS_MAX) : ps_i;
    last_v = (CW'(1) << (BASE_LOG2 + int'(eff))) - CW'(1);
  end

  assign tmo_o = active_i & rise_i & ~clr_i & (cnt_q == last_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || !active_i) cnt_q <= '0;
    else if (rise_i) cnt_q <= tmo_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_guard_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       irq_ack_i,
  input  logic       cause_clr_i,
  input  logic       tmo_i,
  output logic [7:0] regs_o,
  output logic       accept_o,
  output logic       active_o,
  output logic       irq_o,
  output logic       sys_rst_o,
  output logic       cause_o
);
  localparam int WW = $clog2(WIN_CYCLES + 1);

  wdt_reg_t      wd;
  logic          run_q, ie_q, flag_q, cause_q, pulse_q;
  logic [3:0]    ps_q;
  logic [WW-1:0] win_q;
  logic          open_w, opener_w, tmo_irq, tmo_rst;

  assign wd       = wr_data_i;
  assign open_w   = (win_q != '0);
  assign accept_o = wr_en_i & open_w;
  assign opener_w = wr_en_i & ~open_w & wd.unlock & wd.run;
  assign tmo_irq  = tmo_i & ie_q;
  assign tmo_rst  = tmo_i & ~ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      cause_q <= 1'b0;
      pulse_q <= 1'b0;
      ps_q    <= '0;
    end else begin
      if (accept_o) win_q <= '0;
      else if (opener_w) win_q <= WW'(WIN_CYCLES);
      else if (open_w) win_q <= win_q - WW'(1);

      if (tmo_rst) run_q <= 1'b1;
      else if (accept_o) run_q <= wd.run | cause_q;
      else if (wr_en_i && wd.run) run_q <= 1'b1;

      // combined mode: hardware drops the enable so the next time-out resets
      if (tmo_irq && run_q) ie_q <= 1'b0;
      else if (wr_en_i) ie_q <= wd.ie;

      if (accept_o) ps_q <= wd.ps;

      if (tmo_irq) flag_q <= 1'b1;
      else if (irq_ack_i || (wr_en_i && wd.flag)) flag_q <= 1'b0;

      if (tmo_rst) cause_q <= 1'b1;
      else if (cause_clr_i) cause_q <= 1'b0;

      pulse_q <= tmo_rst;
    end
  end

  assign regs_o    = {ps_q, open_w, flag_q, ie_q, run_q};
  assign active_o  = run_q | ie_q;
  assign irq_o     = flag_q;
  assign sys_rst_o = pulse_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_LOG2   = 11,
  parameter int WIN_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       irq_ack_i,
  input  logic       cause_clr_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       sys_rst_o,
  output logic       cause_o
);
  logic       rise, tmo, accept, active;
  logic [7:0] regs;

  wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rise_o(rise)
  );

  wdt_count #(.BASE_LOG2(BASE_LOG2)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .clr_i   (kick_i | accept),
    .rise_i  (rise),
    .ps_i    (regs[7:4]),
    .tmo_o   (tmo)
  );

  wdt_cfg #(.WIN_CYCLES(WIN_CYCLES)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .irq_ack_i  (irq_ack_i),
    .cause_clr_i(cause_clr_i),
    .tmo_i      (tmo),
    .regs_o     (regs),
    .accept_o   (accept),
    .active_o   (active),
    .irq_o      (irq_o),
    .sys_rst_o  (sys_rst_o),
    .cause_o    (cause_o)
  );

  assign rd_data_o = regs;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       irq_ack_i,
  input logic       tmo_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       sys_rst_o,
  input logic       cause_o
);
  // R4
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);

  // R4
  rst_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !rd_data_o[1]) |=> sys_rst_o);

  // R7
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (cause_o && rd_data_o[0]));

  // R7
  run_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o |-> rd_data_o[0]);

  // R5
  irq_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && rd_data_o[1] && !rd_data_o[0]) |=> (irq_o && rd_data_o[1] && !sys_rst_o));

  // R6
  combined_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && rd_data_o[1] && rd_data_o[0]) |=> (irq_o && !rd_data_o[1] && !sys_rst_o));

  // R9
  ps_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && rd_data_o[3]) |-> $stable(rd_data_o[7:4]));

  // R12
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !tmo_i) |=> !irq_o);
endmodule

bind wdt_guard wdt_guard_chk chk_u (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .irq_ack_i(irq_ack_i),
  .tmo_i    (tmo),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o),
  .sys_rst_o(sys_rst_o),
  .cause_o  (cause_o)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_BASE    = 2;
  localparam int TB_WIN     = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       irq_ack_i = 1'b0;
  logic       cause_clr_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o, sys_rst_o, cause_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  wdt_guard #(.BASE_LOG2(TB_BASE), .WIN_CYCLES(TB_WIN), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .irq_ack_i(irq_ack_i),
    .cause_clr_i(cause_clr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o), .cause_o(cause_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    repeat (3) @(negedge clk_i);
    forever begin
      repeat (2) @(negedge clk_i);
      tick_i = ~tick_i;
    end
  end

  // reference model
  bit m_run, m_ie, m_flag, m_cause, m_pulse;
  int m_ps, m_cnt, m_win;
  bit hist[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_ie = 0; m_flag = 0; m_cause = 0; m_pulse = 0;
      m_ps = 0; m_cnt = 0; m_win = 0;
      hist = '{0, 0, 0};
    end else begin
      bit edge_seen, acc, tmo, n_run, n_ie, n_flag, n_cause;
      int lim, n_win, n_ps;
      edge_seen = hist[1] && !hist[2];
      lim = (1 << TB_BASE) << ((m_ps > 9) ? 9 : m_ps);
      acc = wr_en_i && (m_win > 0);
      tmo = (m_run || m_ie) && edge_seen && !(kick_i || acc) && (m_cnt == lim - 1);
      n_run = m_run; n_ie = m_ie; n_flag = m_flag; n_cause = m_cause;
      n_win = m_win; n_ps = m_ps;
      if (acc) begin
        n_run = wr_data_i[0] || m_cause;
        n_ie = wr_data_i[1];
        n_ps = int'(wr_data_i[7:4]);
        n_win = 0;
      end else if (wr_en_i) begin
        if (wr_data_i[0]) n_run = 1;
        n_ie = wr_data_i[1];
        if (wr_data_i[3] && wr_data_i[0]) n_win = TB_WIN;
      end else if (m_win > 0) n_win = m_win - 1;
      if (irq_ack_i || (wr_en_i && wr_data_i[2])) n_flag = 0;
      if (cause_clr_i) n_cause = 0;
      m_pulse = 0;
      if (tmo) begin
        if (m_ie) begin
          n_flag = 1;
          if (m_run) n_ie = 0;
        end else begin
          m_pulse = 1; n_cause = 1; n_run = 1;
        end
      end
      if (kick_i || acc || !(m_run || m_ie)) m_cnt = 0;
      else if (edge_seen) m_cnt = tmo ? 0 : m_cnt + 1;
      m_run = n_run; m_ie = n_ie; m_flag = n_flag; m_cause = n_cause;
      m_win = n_win; m_ps = n_ps;
      hist.push_front(tick_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(rd_data_o == {4'(m_ps), m_win > 0, m_flag, m_ie, m_run}, "R10 register view",
          rd_data_o, {4'(m_ps), m_win > 0, m_flag, m_ie, m_run});
      chk(sys_rst_o == m_pulse, "R4 reset pulse", sys_rst_o, m_pulse);
      chk(irq_o == m_flag, "R5 irq", irq_o, m_flag);
      chk(cause_o == m_cause, "R7 cause", cause_o, m_cause);
      if (sys_rst_o) pulses++;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic kick();
    @(negedge clk_i); kick_i = 1;
    @(negedge clk_i); kick_i = 0;
  endtask

  task automatic setmode(input logic [7:0] d);
    kick();
    @(negedge clk_i); cause_clr_i = 1;
    @(negedge clk_i); cause_clr_i = 0;
    wr(8'h09);
    wr(d);
  endtask

  task automatic wait_for(input bit want_rst, output int n);
    n = 0;
    while ((want_rst ? sys_rst_o : irq_o) !== 1'b1 && n < 20000) begin
      @(negedge clk_i); n++;
    end
  endtask

  task automatic measure(input logic [7:0] d, output int n);
    setmode(d);
    @(posedge tick_i);
    kick();
    wait_for(1, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, n9, n12, p0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk(rd_data_o == 8'h00 && !irq_o && !sys_rst_o && !cause_o, "R1 reset state", rd_data_o, 0);

    // R4 reset-only mode
    wr(8'h01);
    wait_for(1, n);
    chk(sys_rst_o == 1, "R4 pulse seen", sys_rst_o, 1);
    @(negedge clk_i);
    chk(sys_rst_o == 0, "R4 pulse width", sys_rst_o, 0);
    chk(cause_o == 1, "R7 cause set", cause_o, 1);

    // R7 disable refused while cause set
    kick();
    wr(8'h09);
    wr(8'h00);
    chk(rd_data_o[0] == 1, "R7 run locked", rd_data_o[0], 1);
    setmode(8'h00);
    chk(rd_data_o == 8'h00 && !cause_o, "R7 R10 disabled after cause clear", rd_data_o, 0);

    // R8 window lifetime
    wr(8'h09);
    chk(rd_data_o[3] == 1, "R8 window open", rd_data_o[3], 1);
    repeat (3) @(negedge clk_i);
    chk(rd_data_o[3] == 1, "R8 window last cycle", rd_data_o[3], 1);
    @(negedge clk_i);
    chk(rd_data_o[3] == 0, "R8 window expired", rd_data_o[3], 0);
    kick();
    wr(8'hF0);
    // R9
    chk(rd_data_o[0] == 1 && rd_data_o[7:4] == 0, "R9 R10 late write ignored", rd_data_o, 8'h01);

    // R5 interrupt-only
    setmode(8'h02);
    p0 = pulses;
    wait_for(0, n);
    chk(irq_o == 1 && rd_data_o[1] == 1, "R5 irq with enable kept", rd_data_o, 8'h06);
    wr(8'h06);
    chk(irq_o == 0 && rd_data_o[1] == 1, "R12 write-one clear", rd_data_o, 8'h02);
    wait_for(0, n);
    @(negedge clk_i); irq_ack_i = 1;
    @(negedge clk_i); irq_ack_i = 0;
    chk(irq_o == 0, "R12 ack clear", irq_o, 0);
    chk(pulses == p0, "R5 no reset", pulses, p0);

    // R6 combined mode
    setmode(8'h13);
    wait_for(0, n);
    chk(rd_data_o[1] == 0 && !sys_rst_o, "R6 enable dropped", rd_data_o, 8'h15);
    wait_for(1, n);
    chk(sys_rst_o == 1, "R6 second time-out resets", sys_rst_o, 1);

    // R11 kicks hold off the time-out
    setmode(8'h01);
    p0 = pulses;
    for (int i = 0; i < 20; i++) begin
      repeat (7) @(negedge clk_i);
      kick();
    end
    chk(pulses == p0, "R11 kicks prevent reset", pulses, p0);

    // R2 R3 exact time-out lengths
    measure(8'h01, n);
    chk(n == 4*4 - 3, "R2 R3 code 0", n, 4*4 - 3);
    measure(8'h11, n);
    chk(n == 4*8 - 3, "R3 code 1", n, 4*8 - 3);
    measure(8'h91, n9);
    chk(n9 == 4*2048 - 3, "R3 code 9", n9, 4*2048 - 3);
    measure(8'hC1, n12);
    chk(n12 == n9, "R3 reserved code clamps", n12, n9);

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule